// File: doc/BRIEF.md
# ECC Memory Write Controller

This block sits between a processor's load/store port and a 64-bit memory that stores 8 extra check bits beside each word. On every memory write it computes a single-error-correct, double-error-detect (SECDED) check byte and sends it on a separate check bus. When a store covers fewer than all eight bytes, it first reads the stored word and corrects it if needed. It then merges the new bytes and writes the whole word back with a fresh code. On loads it decodes the returned word and fixes single-bit faults. It flags both correctable and uncorrectable faults, and it records the first fault in a small log until software re-arms that log.

Two features exist for validation. An 8-bit inversion mask is XORed into every check byte that is written, so that later loads see known faults. A write-only bypass switch lets partial stores go straight to memory without the read-modify-write. The switch can only be changed while checking is off, and it has no effect on the load path.

Top module: `ecc_wr_ctrl`

## Requirements
- R1: Check code: data bit k (k = 0..63) takes, in ascending order, the k-th codeword position in 1..71 that is not a power of two. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. A full-width store (byte enable 8'hFF) writes its data unchanged, with check byte = code(data) XOR mask, in one memory cycle, and busy is high for 1 cycle.
- R2: The mask sits in bits 7:0 of register 1 and is XORed into the check byte of every memory write. A mask of 8'h01 makes a later checked load of that word report a correctable error with syndrome 8'h81 and unchanged data.
- R3: With checking enabled and the bypass clear, a store with byte enable other than 8'hFF reads the word, corrects a single-bit fault, replaces the bytes whose enable bit is 1, and writes the result with a fresh check byte. Busy is high for 3 cycles.
- R4: With the bypass set (register 1 bit 31) and checking enabled, a partial store writes its whole 64-bit request data directly in one cycle, with a check byte consistent with that data.
- R5: A write of the bypass bit while checking is enabled (register 0 bit 3 = 1) is ignored.
- R6: A checked load takes busy high for 2 cycles, then gives a one-cycle response. Syndrome = {total parity of the 72 received bits, received check[6:0] XOR recomputed check[6:0]}. Odd total parity means correctable: the data bit at the syndrome position is flipped and the correctable flag is set. Even parity with a nonzero syndrome means uncorrectable: the data is returned raw and the uncorrectable flag is set.
- R7: Load checking, correction and logging behave the same whether the bypass is set or clear.
- R8: On a checked error while register 0 bit 0 (the log lock) is 0, the block records syndrome, correctable flag and uncorrectable flag in register 2 (bits 7:0, 8, 9) and the word address in register 3, then sets the lock. While the lock is 1, later errors leave the log unchanged. Software writing the lock to 0 re-arms the log.
- R9: After reset busy, mem_valid and rsp_valid are 0, and registers 0, 1 (mask), 2 and 3 read 0.
- R10: With checking disabled, loads return raw data with both flags 0 and no logging, and partial stores are written directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| busy | output | 1 | Sequence in progress, new requests held off |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_rdata | output | 64 | Load data, corrected when possible |
| rsp_ce | output | 1 | Correctable error on this load |
| rsp_ue | output | 1 | Uncorrectable error on this load |
| mem_valid | output | 1 | Memory access strobe |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_wcheck | output | 8 | Memory write check byte |
| mem_rdata | input | 64 | Memory read data, valid the cycle after a read strobe |
| mem_rcheck | input | 8 | Memory read check byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 test, 2 log, 3 capture |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
Suppose the sequencer state goes wrong: the busy count per request changes at once, and a merge or check byte error shows up in the stored word on the very memory write where it happens. Suppose the bypass or mask register holds a wrong value: the next partial store runs for the wrong number of cycles, or the stored check byte is off, and a later load reports a fault that should not exist. Suppose the log lock is stuck or never sets: the next injected fault either leaves the log empty or overwrites a held entry, which a register read shows right after that load.

// File: rtl/ecc_wr_ctrl.sv
module ecc_wr_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  input  logic [7:0]    req_be,
  output logic          busy,
  output logic          rsp_valid,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_ce,
  output logic          rsp_ue,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic [7:0]    mem_wcheck,
  input  logic [63:0]   mem_rdata,
  input  logic [7:0]    mem_rcheck,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} st_t;

  function automatic logic [6:0] enc7(input logic [63:0] d);
    logic [6:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 3; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[j[5:0]]) c ^= p[6:0];
        j++;
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] enc8(input logic [63:0] d);
    logic [6:0] c;
    c = enc7(d);
    return {^d ^ ^c, c};
  endfunction

  function automatic logic [63:0] fix(input logic [63:0] d, input logic [6:0] s);
    logic [63:0] r;
    int j;
    r = d;
    j = 0;
    for (int p = 3; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p[6:0] == s) r[j[5:0]] = ~r[j[5:0]];
        j++;
      end
    end
    return r;
  endfunction

  st_t           st;
  logic          ecc_en, lock, dwe;
  logic [7:0]    mask;
  logic [7:0]    log_syn;
  logic          log_ce, log_ue;
  logic [AW-1:0] log_addr;
  logic          op_wr;
  logic [AW-1:0] op_addr;
  logic [63:0]   op_data;
  logic [7:0]    op_be;

  logic [6:0]  syn7;
  logic        par, err_ce, err_ue;
  logic [63:0] rd_word, merged;
  logic        acc, direct;
  logic        unused_bits;

  assign busy    = (st != S_IDLE);
  assign acc     = req_valid && (st == S_IDLE);
  assign direct  = req_write && ((req_be == 8'hFF) || !ecc_en || dwe);
  assign syn7    = mem_rcheck[6:0] ^ enc7(mem_rdata);
  assign par     = ^{mem_rdata, mem_rcheck};
  assign err_ce  = ecc_en && par;
  assign err_ue  = ecc_en && !par && (syn7 != 7'd0);
  assign rd_word = err_ce ? fix(mem_rdata, syn7) : mem_rdata;
  assign unused_bits = ^reg_wdata[30:8];

  always_comb
    for (int b = 0; b < 8; b++)
      merged[8*b +: 8] = op_be[b] ? op_data[8*b +: 8] : rd_word[8*b +: 8];

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {28'd0, ecc_en, 2'b00, lock};
      2'd1:    reg_rdata = {24'd0, mask};
      2'd2:    reg_rdata = {22'd0, log_ue, log_ce, log_syn};
      default: reg_rdata = 32'(log_addr);
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ecc_en <= 1'b0; lock <= 1'b0; dwe <= 1'b0; mask <= '0;
      log_syn <= '0; log_ce <= 1'b0; log_ue <= 1'b0; log_addr <= '0;
      op_wr <= 1'b0; op_addr <= '0; op_data <= '0; op_be <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_ce <= 1'b0; rsp_ue <= 1'b0;
      mem_valid <= 1'b0; mem_write <= 1'b0; mem_addr <= '0;
      mem_wdata <= '0; mem_wcheck <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_valid <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          op_wr <= req_write; op_addr <= req_addr;
          op_data <= req_wdata; op_be <= req_be;
          mem_valid <= 1'b1;
          mem_addr  <= req_addr;
          if (direct) begin
            mem_write  <= 1'b1;
            mem_wdata  <= req_wdata;
            mem_wcheck <= enc8(req_wdata) ^ mask;
            st <= S_WR;
          end else begin
            mem_write <= 1'b0;
            st <= S_RD;
          end
        end
        S_RD: st <= S_WAIT;
        S_WAIT: begin
          if (!op_wr) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_word;
            rsp_ce    <= err_ce;
            rsp_ue    <= err_ue;
            st <= S_IDLE;
          end else begin
            mem_valid  <= 1'b1;
            mem_write  <= 1'b1;
            mem_wdata  <= merged;
            mem_wcheck <= enc8(merged) ^ mask;
            st <= S_WR;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (reg_wr) begin
        if (reg_addr == 2'd0) begin
          ecc_en <= reg_wdata[3];
          lock   <= reg_wdata[0];
        end else if (reg_addr == 2'd1) begin
          mask <= reg_wdata[7:0];
          if (!ecc_en) dwe <= reg_wdata[31];
        end
      end
      if ((st == S_WAIT) && (err_ce || err_ue) && !lock) begin
        log_syn  <= {par, syn7};
        log_ce   <= err_ce;
        log_ue   <= err_ue;
        log_addr <= op_addr;
        lock     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecc_wr_ctrl_chk.sv
module ecc_wr_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_ce,
  input logic          rsp_ue,
  input logic          mem_valid,
  input logic          mem_write,
  input logic [63:0]   mem_wdata,
  input logic [7:0]    mem_wcheck,
  input logic [7:0]    mask,
  input logic          lock,
  input logic          ecc_en,
  input logic          dwe,
  input logic [7:0]    log_syn,
  input logic [AW-1:0] log_addr
);

  function automatic logic [7:0] code_of(input logic [63:0] d);
    logic [6:0] c;
    int k;
    c = '0;
    k = 0;
    for (int q = 1; q < 72; q++) begin
      if ((q & (q - 1)) != 0) begin
        c ^= d[k[5:0]] ? q[6:0] : 7'd0;
        k++;
      end
    end
    return {^{d, c}, c};
  endfunction

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy); // R3

  AST_MEM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> !mem_valid); // R1

  AST_WCHECK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && $stable(mask) |-> mem_wcheck == (code_of(mem_wdata) ^ mask)); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_ce && rsp_ue)); // R6

  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock && $past(lock) |-> $stable(log_syn) && $stable(log_addr)); // R8

  AST_BYPASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_en && $past(ecc_en) |-> $stable(dwe)); // R5

endmodule

bind ecc_wr_ctrl ecc_wr_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/ecc_wr_ctrl_bench.sv
`timescale 1ns/1ps
module ecc_wr_ctrl_bench;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0] req_be = '0;
  logic busy, rsp_valid, rsp_ce, rsp_ue, mem_valid, mem_write;
  logic [63:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wcheck;
  logic [63:0] mem_rdata = '0;
  logic [7:0] mem_rcheck = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #4 clk = ~clk;

  ecc_wr_ctrl #(.AW(AW)) u_ecc_wr_ctrl (.*);

  logic [71:0] mem [16];
  always @(posedge clk)
    if (mem_valid) begin
      if (mem_write) mem[mem_addr[3:0]] <= {mem_wcheck, mem_wdata};
      else {mem_rcheck, mem_rdata} <= mem[mem_addr[3:0]];
    end

  int n_chk = 0, n_fail = 0;
  int pos_tab [64];
  logic m_en = 0, m_dwe = 0, m_lock = 0, m_lce = 0, m_lue = 0;
  logic [7:0] m_mask = 0, m_syn = 0;
  logic [15:0] m_laddr = 0;

  initial begin
    int p;
    p = 1;
    for (int k = 0; k < 64; k++) begin
      while ((p & (p - 1)) == 0) p++;
      pos_tab[k] = p;
      p++;
    end
  end

  function automatic logic [7:0] b_code(input logic [63:0] d);
    logic [6:0] c;
    c = 0;
    for (int k = 0; k < 64; k++) if (d[k]) c = c ^ pos_tab[k][6:0];
    return {^{d, c}, c};
  endfunction

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic decode(input logic [71:0] w, output logic [63:0] d, output logic ce,
                        output logic ue, output logic [7:0] syn);
    logic [6:0] s;
    logic pr;
    d = w[63:0];
    s = w[70:64] ^ b_code(w[63:0])[6:0];
    pr = ^w;
    syn = {pr, s};
    ce = m_en && pr;
    ue = m_en && !pr && (s != 0);
    if (ce) for (int k = 0; k < 64; k++) if (pos_tab[k] == int'(s)) d[k] = ~d[k];
    if (!m_en) begin ce = 0; ue = 0; end
  endtask

  task automatic model_log(input logic ce, input logic ue, input logic [7:0] syn, input logic [15:0] a);
    if ((ce || ue) && !m_lock) begin
      m_syn = syn; m_lce = ce; m_lue = ue; m_laddr = a; m_lock = 1;
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 0) begin m_en = d[3]; m_lock = d[0]; end
    if (a == 1) begin m_mask = d[7:0]; if (!m_en) m_dwe = d[31]; end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check_log(input string tag);
    logic [31:0] v;
    reg_read(2, v);
    chk({tag, " log"}, 72'(v), 72'({m_lue, m_lce, m_syn}));
    reg_read(3, v);
    chk({tag, " capture"}, 72'(v), 72'(m_laddr));
    reg_read(0, v);
    chk({tag, " ctrl"}, 72'(v), 72'({m_en, 2'b00, m_lock}));
  endtask

  task automatic run_op(input logic wr, input logic [15:0] a, input logic [63:0] d,
                        input logic [7:0] be, output int nb);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    nb = 0;
    while (busy && nb < 10) begin nb++; @(negedge clk); end
  endtask

  task automatic do_write(input string tag, input logic [15:0] a, input logic [63:0] d, input logic [7:0] be);
    logic [63:0] old, mg;
    logic ce, ue;
    logic [7:0] syn;
    logic [71:0] exp;
    logic rmw;
    int nb;
    rmw = (be != 8'hFF) && m_en && !m_dwe;
    if (rmw) begin
      decode(mem[a[3:0]], old, ce, ue, syn);
      for (int b = 0; b < 8; b++) mg[8*b +: 8] = be[b] ? d[8*b +: 8] : old[8*b +: 8];
      exp = {b_code(mg) ^ m_mask, mg};
      model_log(ce, ue, syn, a);
    end else exp = {b_code(d) ^ m_mask, d};
    run_op(1, a, d, be, nb);
    chk({tag, " busy cycles"}, 72'(nb), rmw ? 72'd3 : 72'd1);
    chk({tag, " stored word"}, mem[a[3:0]], exp);
  endtask

  task automatic do_read(input string tag, input logic [15:0] a);
    logic [63:0] ed;
    logic ce, ue;
    logic [7:0] syn;
    int nb;
    decode(mem[a[3:0]], ed, ce, ue, syn);
    model_log(ce, ue, syn, a);
    run_op(0, a, 64'd0, 8'd0, nb);
    chk({tag, " busy cycles"}, 72'(nb), 72'd2);
    chk({tag, " rsp_valid"}, 72'(rsp_valid), 72'd1);
    chk({tag, " data"}, 72'(rsp_rdata), 72'(ed));
    chk({tag, " flags"}, 72'({rsp_ce, rsp_ue}), 72'({ce, ue}));
  endtask

  task automatic flip(input int a, input int b);
    @(negedge clk);
    mem[a][b] = ~mem[a][b];
  endtask

  always @(negedge clk)
    if (rst_n && mem_valid && mem_write)
      chk("R1 check byte on bus", 72'(mem_wcheck), 72'(b_code(mem_wdata) ^ m_mask));

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset busy/mem_valid/rsp_valid", 72'({busy, mem_valid, rsp_valid}), 72'd0);
    check_log("R9 reset");
    reg_read(1, v);
    chk("R9 reset mask", 72'(v[7:0]), 72'd0);

    for (int i = 0; i < 8; i++)
      do_write("R1 full store", 16'(i), {32'hA5C3_0000 + 32'(i), 32'h1234_5678 ^ 32'(i * 977)}, 8'hFF);

    reg_write(0, 32'h8);
    do_read("R6 clean load", 1);
    do_write("R3 partial low half", 2, 64'hDEAD_BEEF_CAFE_F00D, 8'h0F);
    do_write("R3 partial sparse", 7, 64'h1111_2222_3333_4444, 8'b1010_0101);

    reg_write(1, 32'h8000_0000);
    do_write("R5 bypass write ignored", 3, 64'hFFEE_DDCC_BBAA_9988, 8'hF0);

    flip(0, 5);
    do_read("R6 single data bit", 0);
    check_log("R8 first error logged");

    flip(1, 7); flip(1, 40);
    do_read("R6 double error", 1);
    check_log("R8 log held while locked");

    reg_write(0, 32'h8);
    do_read("R8 re-armed double", 1);
    check_log("R8 re-armed log");

    reg_write(0, 32'h8);
    reg_write(1, 32'h01);
    do_write("R2 masked full store", 4, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF);
    reg_write(1, 32'h00);
    do_read("R2 masked word load", 4);
    check_log("R2 mask syndrome");

    reg_write(0, 32'h8);
    flip(5, 60);
    do_write("R3 partial over single fault", 5, 64'h0000_0000_0000_00AB, 8'h01);
    check_log("R3 merge fault logged");

    reg_write(0, 32'h0);
    reg_write(1, 32'h8000_0000);
    reg_write(0, 32'h8);
    do_write("R4 bypass partial store", 6, 64'h7766_5544_3322_1100, 8'h01);
    flip(6, 10);
    do_read("R7 load with bypass set", 6);
    check_log("R7 log with bypass set");

    reg_write(0, 32'h0);
    do_read("R10 unchecked double", 1);
    check_log("R10 no logging");
    do_write("R10 unchecked partial", 9, 64'h0102_0304_0506_0708, 8'h3C);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule